// File: doc/BRIEF.md
# Frame Event Interrupt Status Register

This block builds the 8-bit status byte that a camera host interface shows to its host processor. Four sticky event flags live in the byte. A frame-start flag is captured on the rising edge of the vertical envelope. A frame-end flag is captured on the falling edge of the same signal. A controller-alert flag is set by a pulse from the internal controller, and a FIFO-error flag is set by a pulse from the FIFO logic. Each flag stays set until the host writes a one to its own bit of a separate clear register.

Two further bits are not stored. They copy the live FIFO-ready and access-ready levels. The top bit is a summary interrupt. It is high whenever any sticky flag is pending and that flag's mask bit is set. The same value also drives a dedicated interrupt pin.

The FIFO, the controller and the register-access logic sit outside this block. Their results arrive as plain inputs. All inputs are assumed to be synchronous to the register clock. No data stream crosses the block, so every pin is a plain control or status signal.

Top module: `frame_evt_status`

## Requirements
- R1: While reset is active, and right after it is released with no events, all four sticky flags read zero and the interrupt bit and the irq_o pin are low.
- R2: A rising edge on env_i sets the frame-start flag at status bit 4. The flag is visible one clock edge after the edge is presented.
- R3: A falling edge on env_i sets the frame-end flag at status bit 5. The flag is visible one clock edge after the edge is presented.
- R4: A one-cycle pulse on ctl_alert_i sets status bit 3. A one-cycle pulse on fifo_err_i sets status bit 2. Each flag is visible one clock edge later.
- R5: Every sticky flag holds its value until a clear write (clr_we_i high) carries a one in its own bit. The clear bits are: bit 5 for frame-end, bit 4 for frame-start, bit 3 for alert, bit 2 for FIFO error. A written one in bits 7, 6, 1 or 0 has no effect, and a written zero leaves its flag unchanged.
- R6: When a set event and a clear write reach the same flag in the same cycle, the flag ends up set.
- R7: Status bit 1 equals fifo_rdy_i and status bit 0 equals acc_rdy_i in the same cycle. Clear writes do not affect either bit.
- R8: Status bit 6 always reads zero.
- R9: Status bit 7 and irq_o are high exactly when some sticky flag is set and its mask bit in irq_mask_i is set. The mask bits are: bit 0 for FIFO error, bit 1 for alert, bit 2 for frame-start, bit 3 for frame-end.
- R10: A change of irq_mask_i alone changes status bit 7 and irq_o in the same cycle and leaves the flags untouched.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Register clock |
| rst_n | input | 1 | Asynchronous active-low reset |
| env_i | input | 1 | Vertical envelope of the output image, synchronous |
| ctl_alert_i | input | 1 | Internal controller event pulse |
| fifo_err_i | input | 1 | FIFO error pulse |
| fifo_rdy_i | input | 1 | Live FIFO-ready level |
| acc_rdy_i | input | 1 | Live access-ready level |
| irq_mask_i | input | 4 | Per-source interrupt enables |
| clr_we_i | input | 1 | Clear-register write strobe |
| clr_data_i | input | 8 | Clear-register write data |
| status_o | output | 8 | Status byte |
| irq_o | output | 1 | Summary interrupt request |

## Verification
Timing differs by result:
- Flag results (envelope edges, pulses and clear writes) are registered. They appear after the first clock edge that sees the stimulus.
- The reserved bit, the two level bits and the masked summary are combinational. They follow their inputs within the same cycle.

The driver sets each cycle's inputs on the falling edge and queues the byte expected after the next rising edge. The monitor compares 1 ns after that rising edge. This one-edge delay covers the flags. The combinational bits are correct by then too, because their inputs have not changed since the falling edge.

// File: rtl/fes_pkg.sv
package fes_pkg;
  localparam int STATUS_W = 8;
  localparam int NUM_SRC  = 4;
  // Sticky flag i lives at status bit FLAG_LSB+i and is cleared by clear bit FLAG_LSB+i.
  localparam int FLAG_LSB = 2;
  localparam int IRQ_BIT  = 7;
  localparam int RSV_BIT  = 6;
  localparam int FRDY_BIT = 1;
  localparam int RDY_BIT  = 0;

  typedef enum logic [1:0] {
    SRC_FERR = 2'd0,
    SRC_MCI  = 2'd1,
    SRC_SOF  = 2'd2,
    SRC_EOF  = 2'd3
  } src_e;
endpackage

// File: rtl/fes_edge_detect.sv
module fes_edge_detect (
  input  logic clk,
  input  logic rst_n,
  input  logic sig_i,
  output logic rise_o,
  output logic fall_o
);
  logic sig_q;

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) sig_q <= 1'b0;
    else        sig_q <= sig_i;
  end

  assign rise_o = sig_i & ~sig_q;
  assign fall_o = ~sig_i & sig_q;
endmodule

// File: rtl/fes_sticky_flags.sv
module fes_sticky_flags #(
  parameter int N = 4
) (
  input  logic         clk,
  input  logic         rst_n,
  input  logic [N-1:0] set_i,
  input  logic [N-1:0] clr_i,
  output logic [N-1:0] flag_o
);
  logic [N-1:0] flag_q;

  for (genvar i = 0; i < N; i++) begin : g_flag
    always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n)        flag_q[i] <= 1'b0;
      else if (set_i[i]) flag_q[i] <= 1'b1;
      else if (clr_i[i]) flag_q[i] <= 1'b0;
    end

    p_set_wins_r6: assert property (@(posedge clk) disable iff (!rst_n)
      set_i[i] |=> flag_q[i]);
    p_clear_r5: assert property (@(posedge clk) disable iff (!rst_n)
      (clr_i[i] && !set_i[i]) |=> !flag_q[i]);
    p_hold_r5: assert property (@(posedge clk) disable iff (!rst_n)
      (!clr_i[i] && !set_i[i]) |=> $stable(flag_q[i]));
  end

  assign flag_o = flag_q;
endmodule

// File: rtl/frame_evt_status.sv
module frame_evt_status
  import fes_pkg::*;
(
  input  logic                clk,
  input  logic                rst_n,
  input  logic                env_i,
  input  logic                ctl_alert_i,
  input  logic                fifo_err_i,
  input  logic                fifo_rdy_i,
  input  logic                acc_rdy_i,
  input  logic [NUM_SRC-1:0]  irq_mask_i,
  input  logic                clr_we_i,
  input  logic [STATUS_W-1:0] clr_data_i,
  output logic [STATUS_W-1:0] status_o,
  output logic                irq_o
);
  logic               env_rise, env_fall;
  logic [NUM_SRC-1:0] set_vec, clr_vec, flags;
  logic               irq_sum;

  fes_edge_detect u_env_edge (
    .clk    (clk),
    .rst_n  (rst_n),
    .sig_i  (env_i),
    .rise_o (env_rise),
    .fall_o (env_fall)
  );

  always_comb begin
    set_vec           = '0;
    set_vec[SRC_FERR] = fifo_err_i;
    set_vec[SRC_MCI]  = ctl_alert_i;
    set_vec[SRC_SOF]  = env_rise;
    set_vec[SRC_EOF]  = env_fall;
  end

  for (genvar i = 0; i < NUM_SRC; i++) begin : g_clr
    assign clr_vec[i] = clr_we_i & clr_data_i[FLAG_LSB+i];
  end

  fes_sticky_flags #(.N(NUM_SRC)) u_flags (
    .clk    (clk),
    .rst_n  (rst_n),
    .set_i  (set_vec),
    .clr_i  (clr_vec),
    .flag_o (flags)
  );

  assign irq_sum = |(flags & irq_mask_i);

  always_comb begin
    status_o                                = '0;
    status_o[IRQ_BIT]                       = irq_sum;
    status_o[RSV_BIT]                       = 1'b0;
    status_o[FLAG_LSB+NUM_SRC-1:FLAG_LSB]   = flags;
    status_o[FRDY_BIT]                      = fifo_rdy_i;
    status_o[RDY_BIT]                       = acc_rdy_i;
  end

  assign irq_o = irq_sum;

  p_sof_rise_r2: assert property (@(posedge clk) disable iff (!rst_n)
    $rose(env_i) |=> status_o[FLAG_LSB+SRC_SOF]);
  p_eof_fall_r3: assert property (@(posedge clk) disable iff (!rst_n)
    $fell(env_i) |=> status_o[FLAG_LSB+SRC_EOF]);
  p_irq_needs_mask_r9: assert property (@(posedge clk) disable iff (!rst_n)
    irq_o |-> (|irq_mask_i));
endmodule

// File: tb/frame_evt_status_bench.sv
module frame_evt_status_bench;
  logic       clk = 1'b0;
  logic       rst_n = 1'b0;
  logic       env = 1'b0, alert = 1'b0, ferr = 1'b0, frdy = 1'b0, rdy = 1'b0;
  logic [3:0] mask = '0;
  logic       clr_we = 1'b0;
  logic [7:0] clr_d = '0;
  logic [7:0] status;
  logic       irq;

  int checks = 0, failures = 0;
  logic [8:0] exp_q[$];
  string      tag_q[$];

  // bench model state: index 0 FERR, 1 MCI, 2 SOF, 3 EOF
  logic [3:0] m_flags = '0;
  logic       m_env = 1'b0;

  always #5 clk = ~clk;

  frame_evt_status u_frame_evt_status (
    .clk(clk), .rst_n(rst_n), .env_i(env), .ctl_alert_i(alert), .fifo_err_i(ferr),
    .fifo_rdy_i(frdy), .acc_rdy_i(rdy), .irq_mask_i(mask), .clr_we_i(clr_we),
    .clr_data_i(clr_d), .status_o(status), .irq_o(irq)
  );

  function automatic logic [8:0] expect_of(logic [3:0] f, logic [3:0] m, logic fr, logic rd);
    logic s;
    s = |(f & m);
    return {s, s, 1'b0, f[3], f[2], f[1], f[0], fr, rd};
  endfunction

  task automatic check(string tag, logic [8:0] act, logic [8:0] exp);
    checks++;
    if (act !== exp) begin
      failures++;
      $display("FAIL %s actual irq/status=%b expected=%b", tag, act, exp);
    end
  endtask

  // Driver: one call per cycle; applies inputs on the falling edge and queues the expectation.
  task automatic drive(logic e, logic a, logic fe, logic fr, logic rd, logic [3:0] mk,
                       logic cw, logic [7:0] cd, string tag);
    logic [3:0] set, clr;
    @(negedge clk);
    env = e; alert = a; ferr = fe; frdy = fr; rdy = rd; mask = mk; clr_we = cw; clr_d = cd;
    set = {~e & m_env, e & ~m_env, a, fe};
    clr = cw ? cd[5:2] : 4'b0;
    m_flags = set | (m_flags & ~clr);
    m_env = e;
    exp_q.push_back(expect_of(m_flags, mk, fr, rd));
    tag_q.push_back(tag);
  endtask

  // Monitor: compares 1 ns after each rising edge.
  always @(posedge clk) begin
    #1;
    if (exp_q.size() > 0) begin
      logic [8:0] e;
      string t;
      e = exp_q.pop_front();
      t = tag_q.pop_front();
      check(t, {irq, status}, e);
      checks++;
      if (status[6] !== 1'b0) begin
        failures++;
        $display("FAIL R8 reserved bit actual=%b expected=0", status[6]);
      end
    end
  end

  initial begin
    #2_000_000;
    failures++;
    $display("FAIL watchdog actual=timeout expected=finish");
    $display("TB_RESULT checks=%0d failures=%0d", checks, failures);
    $finish;
  end

  initial begin
    frdy = 1'b1; rdy = 1'b1;
    repeat (3) @(posedge clk);
    #1;
    check("R1 in reset", {irq, status}, {1'b0, 8'b0000_0011});
    @(negedge clk); rst_n = 1'b1;
    drive(0,0,0,1,1,4'hF,0,8'h00, "R1 after reset");
    drive(1,0,0,1,1,4'h0,0,8'h00, "R2 rise sets SOF");
    drive(1,0,0,1,1,4'h0,0,8'h00, "R2 held high no new event");
    drive(0,0,0,1,1,4'h0,0,8'h00, "R3 fall sets EOF");
    drive(0,1,0,1,1,4'h0,0,8'h00, "R4 alert sets MCI");
    drive(0,0,1,1,1,4'h0,0,8'h00, "R4 fifo err sets FERR");
    drive(0,0,0,1,1,4'h0,0,8'h00, "R5 flags sticky");
    drive(0,0,0,1,1,4'h0,1,8'hC3, "R5 clear of bits 7 6 1 0 ignored");
    drive(0,0,0,1,1,4'h0,0,8'h3C, "R5 data without strobe ignored");
    drive(0,0,0,1,1,4'h0,1,8'h10, "R5 clear SOF only");
    drive(0,0,0,1,1,4'h1,0,8'h00, "R10 mask FERR raises irq");
    drive(0,0,0,1,1,4'h4,0,8'h00, "R9 mask on cleared SOF no irq");
    drive(0,0,0,1,1,4'h8,1,8'h04, "R9 EOF masked irq, R5 clear FERR");
    drive(0,0,1,1,1,4'h1,1,8'h04, "R6 set beats clear on FERR");
    drive(1,1,0,1,1,4'h0,1,8'h18, "R6 set beats clear on SOF and MCI");
    drive(1,0,0,0,1,4'h0,1,8'hFF, "R7 FRDY low and clear all");
    drive(1,0,0,1,0,4'hF,1,8'h03, "R7 RDY low, clear bits 1 0 ignored");
    drive(0,0,0,0,0,4'h8,0,8'h00, "R3 second fall with R9 mask EOF");
    drive(0,0,0,1,1,4'h2,1,8'h20, "R5 clear EOF, R9 MCI masked off");
    drive(0,0,0,1,1,4'h0,0,8'h00, "R1 idle end");
    repeat (3) @(posedge clk);
    #2;
    $display("TB_RESULT checks=%0d failures=%0d", checks, failures);
    $finish;
  end
endmodule